// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the memory side of a single-data-rate low-power SDRAM interface. On every rising clock edge it samples the command pins: clock enable, chip select, the row and column strobes, write enable, the data mask, a 13-bit address and a 2-bit bank select. It resolves them into one command. It keeps a record of which of the four banks hold an open row and which row that is. It also holds the two mode registers, an internal refresh row counter and the power state. It reports any command that breaks the bank or mode rules.

Everything is registered at the capturing edge. A command driven before edge k is visible on the outputs after edge k. The same strobe pattern can mean two different things. Clock enable picks between burst stop and deep power down, and between auto refresh and self refresh. Address bit 10 picks auto precharge on an access and all-bank precharge on a precharge. The bank bits pick the target mode register.

The data mask is reflected at once as a write mask. It is also delayed by two further clocks to form the read output enable.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select low, the strobes {ras_n,cas_n,we_n} decode as follows: 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 001 auto refresh, 000 mode set. Chip select high is a no-op. cmd_o shows the command after the capturing edge, using the codes NOP=0, ACT=1, RD=2, WR=3, BST=4, DPD=5, PRE=6, PALL=7, AREF=8, SREF=9, MRS=10, EMRS=11, MRS_BAD=12.
- R2: With cke low, pattern 110 becomes deep power down (DPD) and pattern 001 becomes self refresh (SREF). pwr_o then shows 2 or 1 respectively; 0 means normal.
- R3: A legal activate marks the addressed bank open and stores addr as that bank's row. Bank b's row sits in open_rows_o[13*b +: 13], and bank_open_o[b] is its open flag.
- R4: A precharge with addr[10]=0 closes only the addressed bank (PRE). With addr[10]=1 it is PALL: it closes every bank whatever the bank bits hold.
- R5: A read or write with addr[10]=1 raises auto_pre_o and leaves the target bank closed after the access edge. With addr[10]=0 the bank stays open.
- R6: illegal_o is raised for an activate to an open bank and for a read or write to a closed bank. In both cases the bank flags and stored rows are left unchanged.
- R7: A burst stop is flagged illegal when the most recent legal read or write asked for auto precharge.
- R8: A mode set with bank bits 00 loads addr into mode_o. With bank bits 10 (ba[1]=1) it loads ext_mode_o (EMRS). Bank codes 01 and 11 give MRS_BAD and illegal_o, and write neither register.
- R9: Each auto refresh increments ref_row_o by one, wrapping modulo 2^13.
- R10: In self refresh or deep power down, each edge with cke low reports a no-op and changes no state. The first edge with cke high returns pwr_o to 0 and ignores the command present on that edge.
- R11: wr_mask_o shows the dqm captured at the last edge. rd_oe_o equals the inverse of the dqm captured two edges before that.
- R12: After synchronous reset, all banks are closed and all rows are zero. Both mode registers and ref_row_o are zero, cmd_o is NOP, illegal_o is 0, pwr_o is 0, wr_mask_o is 1 and rd_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge captures all pins |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row / column / op-code bus |
| cmd_o | output | 4 | Decoded command code |
| cmd_bank_o | output | 2 | Bank of the decoded command |
| auto_pre_o | output | 1 | Access requested auto precharge |
| illegal_o | output | 1 | Decoded command broke a rule |
| wr_mask_o | output | 1 | Write data mask for the captured cycle |
| rd_oe_o | output | 1 | Read output enable, delayed |
| pwr_o | output | 2 | Power state: 0 normal, 1 self refresh, 2 deep power down |
| bank_open_o | output | 4 | Open flag per bank |
| open_rows_o | output | 52 | Stored row per bank, 13 bits each |
| mode_o | output | 13 | Mode register |
| ext_mode_o | output | 13 | Extended mode register |
| ref_row_o | output | 13 | Internal refresh row counter |

## Verification
Leaving low power and decoding a command can land on the same edge. When cke returns high while the pins carry an activate, both the power-state update and the bank tracker see that edge. The bench provokes this collision from self refresh. It judges the result on three outputs: cmd_o must read NOP, pwr_o must return to 0, and bank_open_o must stay unchanged. A plain activate one cycle later must then open the bank.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_ACT     = 4'd1,
        CMD_RD      = 4'd2,
        CMD_WR      = 4'd3,
        CMD_BST     = 4'd4,
        CMD_DPD     = 4'd5,
        CMD_PRE     = 4'd6,
        CMD_PALL    = 4'd7,
        CMD_AREF    = 4'd8,
        CMD_SREF    = 4'd9,
        CMD_MRS     = 4'd10,
        CMD_EMRS    = 4'd11,
        CMD_MRS_BAD = 4'd12
    } cmd_t;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_SREF = 2'd1,
        PWR_DPD  = 2'd2
    } pwr_t;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Pin pattern to command; sel is the two-bit mode register select.
    function automatic cmd_t decode_pins(pins_t p, logic a10, logic [1:0] sel);
        cmd_t c;
        c = CMD_NOP;
        if (!p.cs_n) begin
            case ({p.ras_n, p.cas_n, p.we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = p.cke ? CMD_BST : CMD_DPD;
                3'b010:  c = a10 ? CMD_PALL : CMD_PRE;
                3'b001:  c = p.cke ? CMD_AREF : CMD_SREF;
                3'b000: begin
                    if (sel == 2'b00)      c = CMD_MRS;
                    else if (sel == 2'b10) c = CMD_EMRS;
                    else                   c = CMD_MRS_BAD;
                end
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_access(cmd_t c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_dec_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  pins_t             pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BA_W-1:0]   ba_i,
    input  pwr_t              pwr_i,
    output cmd_t              cmd_o,
    output logic              ap_o
);
    cmd_t raw;

    always_comb begin
        raw = decode_pins(pins_i, addr_i[AP_BIT], ba_i[1:0]);
        // any low-power state swallows the command on the pins
        cmd_o = (pwr_i == PWR_ON) ? raw : CMD_NOP;
        ap_o  = is_access(cmd_o) && addr_i[AP_BIT];
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_dec_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BA_W   = 2,
    parameter int ROW_W  = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  cmd_t                   cmd_i,
    input  logic [BA_W-1:0]        bank_i,
    input  logic [ROW_W-1:0]       row_i,
    input  logic                   ap_i,
    output logic                   tgt_open_o,
    output logic [BANKS-1:0]       open_o,
    output logic [BANKS*ROW_W-1:0] rows_o
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;
        logic             hit;

        assign hit = (bank_i == BA_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else begin
                case (cmd_i)
                    CMD_ACT: begin
                        if (hit && !open_r) begin
                            open_r <= 1'b1;
                            row_r  <= row_i;
                        end
                    end
                    CMD_PRE:  if (hit) open_r <= 1'b0;
                    CMD_PALL: open_r <= 1'b0;
                    CMD_RD, CMD_WR: if (hit && ap_i) open_r <= 1'b0;
                    default: ;
                endcase
            end
        end

        assign open_o[g]                   = open_r;
        assign rows_o[g*ROW_W +: ROW_W]    = row_r;
    end

    assign tgt_open_o = open_o[bank_i];
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
    parameter int OE_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm_i,
    output logic mask_o,
    output logic oe_o
);
    localparam int STAGES = OE_LAT + 1;

    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b1;
        else     stage_q[0] <= dqm_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= 1'b1;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign mask_o = stage_q[0];
    assign oe_o   = ~stage_q[STAGES-1];
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_dec_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANKS  = 4,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10,
    parameter int OE_LAT = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic                    dqm,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    output logic [3:0]              cmd_o,
    output logic [BA_W-1:0]         cmd_bank_o,
    output logic                    auto_pre_o,
    output logic                    illegal_o,
    output logic                    wr_mask_o,
    output logic                    rd_oe_o,
    output logic [1:0]              pwr_o,
    output logic [BANKS-1:0]        bank_open_o,
    output logic [BANKS*ADDR_W-1:0] open_rows_o,
    output logic [ADDR_W-1:0]       mode_o,
    output logic [ADDR_W-1:0]       ext_mode_o,
    output logic [ADDR_W-1:0]       ref_row_o
);
    pins_t            pins;
    cmd_t             dec_cmd;
    logic             dec_ap;
    logic             tgt_open;
    logic             bad_d;
    pwr_t             pwr_q, pwr_d;
    cmd_t             cmd_q;
    logic [BA_W-1:0]  bank_q;
    logic             ap_q, bad_q, last_ap_q;
    logic [ADDR_W-1:0] mode_q, emode_q, ref_q;

    assign pins = '{cke: cke, cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    sdram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .AP_BIT (AP_BIT)
    ) u_dec (
        .pins_i (pins),
        .addr_i (addr),
        .ba_i   (ba),
        .pwr_i  (pwr_q),
        .cmd_o  (dec_cmd),
        .ap_o   (dec_ap)
    );

    sdram_bank_tracker #(
        .BANKS (BANKS),
        .BA_W  (BA_W),
        .ROW_W (ADDR_W)
    ) u_banks (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (dec_cmd),
        .bank_i     (ba),
        .row_i      (addr),
        .ap_i       (dec_ap),
        .tgt_open_o (tgt_open),
        .open_o     (bank_open_o),
        .rows_o     (open_rows_o)
    );

    sdram_dqm_pipe #(
        .OE_LAT (OE_LAT)
    ) u_dqm (
        .clk    (clk),
        .rst    (rst),
        .dqm_i  (dqm),
        .mask_o (wr_mask_o),
        .oe_o   (rd_oe_o)
    );

    // rule checks against the state held before this edge
    always_comb begin
        case (dec_cmd)
            CMD_ACT:        bad_d = tgt_open;
            CMD_RD, CMD_WR: bad_d = !tgt_open;
            CMD_BST:        bad_d = last_ap_q;
            CMD_MRS_BAD:    bad_d = 1'b1;
            default:        bad_d = 1'b0;
        endcase
    end

    always_comb begin
        pwr_d = pwr_q;
        if (pwr_q == PWR_ON) begin
            if (dec_cmd == CMD_DPD)       pwr_d = PWR_DPD;
            else if (dec_cmd == CMD_SREF) pwr_d = PWR_SREF;
        end else if (cke) begin
            pwr_d = PWR_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q     <= PWR_ON;
            cmd_q     <= CMD_NOP;
            bank_q    <= '0;
            ap_q      <= 1'b0;
            bad_q     <= 1'b0;
            last_ap_q <= 1'b0;
            mode_q    <= '0;
            emode_q   <= '0;
            ref_q     <= '0;
        end else begin
            pwr_q  <= pwr_d;
            cmd_q  <= dec_cmd;
            bank_q <= ba;
            ap_q   <= dec_ap;
            bad_q  <= bad_d;
            if (is_access(dec_cmd) && !bad_d) last_ap_q <= dec_ap;
            if (dec_cmd == CMD_MRS)  mode_q  <= addr;
            if (dec_cmd == CMD_EMRS) emode_q <= addr;
            if (dec_cmd == CMD_AREF) ref_q   <= ref_q + 1'b1;
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign auto_pre_o = ap_q;
    assign illegal_o  = bad_q;
    assign pwr_o      = pwr_q;
    assign mode_o     = mode_q;
    assign ext_mode_o = emode_q;
    assign ref_row_o  = ref_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
    import sdram_dec_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANKS  = 4,
    parameter int BA_W   = 2,
    parameter int OE_LAT = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                dqm,
    input logic [3:0]          cmd_o,
    input logic [BA_W-1:0]     cmd_bank_o,
    input logic                auto_pre_o,
    input logic                illegal_o,
    input logic                wr_mask_o,
    input logic                rd_oe_o,
    input logic [1:0]          pwr_o,
    input logic [BANKS-1:0]    bank_open_o,
    input logic [ADDR_W-1:0]   mode_o,
    input logic [ADDR_W-1:0]   ext_mode_o
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assert_pall_closes_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_PALL |-> bank_open_o == '0);

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT && !illegal_o) |-> bank_open_o[cmd_bank_o]);

    assert_autopre_closed_R5: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == CMD_RD || cmd_o == CMD_WR) && auto_pre_o) |-> !bank_open_o[cmd_bank_o]);

    assert_nop_clean_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_NOP |-> !illegal_o);

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_o != CMD_MRS |-> $stable(mode_o));

    assert_ext_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_o != CMD_EMRS |-> $stable(ext_mode_o));

    assert_sref_state_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_SREF |-> pwr_o == PWR_SREF);

    assert_dpd_state_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_o == CMD_DPD |-> pwr_o == PWR_DPD);

    assert_lp_ignores_R10: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_o) != PWR_ON |-> cmd_o == CMD_NOP);

    assert_mask_now_R11: assert property (@(posedge clk) disable iff (rst)
        age >= 2'd1 |-> wr_mask_o == $past(dqm));

    if (OE_LAT == 2) begin : g_oe
        assert_oe_delay_R11: assert property (@(posedge clk) disable iff (rst)
            age == 2'd3 |-> rd_oe_o == !$past(dqm, 3));
    end
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .ADDR_W (ADDR_W),
    .BANKS  (BANKS),
    .BA_W   (BA_W),
    .OE_LAT (OE_LAT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dqm         (dqm),
    .cmd_o       (cmd_o),
    .cmd_bank_o  (cmd_bank_o),
    .auto_pre_o  (auto_pre_o),
    .illegal_o   (illegal_o),
    .wr_mask_o   (wr_mask_o),
    .rd_oe_o     (rd_oe_o),
    .pwr_o       (pwr_o),
    .bank_open_o (bank_open_o),
    .mode_o      (mode_o),
    .ext_mode_o  (ext_mode_o)
);

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dqm = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic        auto_pre_o, illegal_o, wr_mask_o, rd_oe_o;
    logic [1:0]  pwr_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_rows_o;
    logic [12:0] mode_o, ext_mode_o, ref_row_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .ba(ba), .addr(addr),
        .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .auto_pre_o(auto_pre_o),
        .illegal_o(illegal_o), .wr_mask_o(wr_mask_o), .rd_oe_o(rd_oe_o),
        .pwr_o(pwr_o), .bank_open_o(bank_open_o), .open_rows_o(open_rows_o),
        .mode_o(mode_o), .ext_mode_o(ext_mode_o), .ref_row_o(ref_row_o)
    );

    // {cke,cs_n,ras_n,cas_n,we_n}, ba, addr, exp cmd, exp illegal, exp open flags
    localparam int NV = 20;
    localparam logic [28:0] VEC [NV] = '{
        {5'b10111, 2'd0, 13'h0000, 4'd0,  1'b0, 4'b0000},
        {5'b10011, 2'd1, 13'h0123, 4'd1,  1'b0, 4'b0010},
        {5'b10011, 2'd1, 13'h0055, 4'd1,  1'b1, 4'b0010},
        {5'b10101, 2'd2, 13'h0000, 4'd2,  1'b1, 4'b0010},
        {5'b10101, 2'd1, 13'h0007, 4'd2,  1'b0, 4'b0010},
        {5'b10110, 2'd0, 13'h0000, 4'd4,  1'b0, 4'b0010},
        {5'b10011, 2'd3, 13'h1FFF, 4'd1,  1'b0, 4'b1010},
        {5'b10100, 2'd3, 13'h0400, 4'd3,  1'b0, 4'b0010},
        {5'b10110, 2'd0, 13'h0000, 4'd4,  1'b1, 4'b0010},
        {5'b10010, 2'd1, 13'h0000, 4'd6,  1'b0, 4'b0000},
        {5'b10011, 2'd0, 13'h0011, 4'd1,  1'b0, 4'b0001},
        {5'b10011, 2'd2, 13'h0ABC, 4'd1,  1'b0, 4'b0101},
        {5'b10100, 2'd0, 13'h0000, 4'd3,  1'b0, 4'b0101},
        {5'b10010, 2'd3, 13'h0400, 4'd7,  1'b0, 4'b0000},
        {5'b10001, 2'd0, 13'h0000, 4'd8,  1'b0, 4'b0000},
        {5'b10000, 2'd0, 13'h0033, 4'd10, 1'b0, 4'b0000},
        {5'b10000, 2'd2, 13'h0102, 4'd11, 1'b0, 4'b0000},
        {5'b10000, 2'd1, 13'h1FFF, 4'd12, 1'b1, 4'b0000},
        {5'b11000, 2'd3, 13'h1FFF, 4'd0,  1'b0, 4'b0000},
        {5'b10000, 2'd3, 13'h0AAA, 4'd12, 1'b1, 4'b0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic apply(input logic [4:0] p, input logic [1:0] b, input logic [12:0] a);
        {cke, cs_n, ras_n, cas_n, we_n} = p;
        ba   = b;
        addr = a;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check_reset(input string tag);
        chk({tag, " open"}, 64'(bank_open_o), 64'h0);
        chk({tag, " rows"}, 64'(open_rows_o), 64'h0);
        chk({tag, " mode"}, 64'({mode_o, ext_mode_o, ref_row_o}), 64'h0);
        chk({tag, " cmd"}, 64'({cmd_o, illegal_o, pwr_o}), 64'h0);
        chk({tag, " dqm"}, 64'({wr_mask_o, rd_oe_o}), 64'b10);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset("R12 initial");

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][28:24], VEC[i][23:22], VEC[i][21:9]);
            chk($sformatf("R1/R3-R8 vec %0d cmd", i), 64'(cmd_o), 64'(VEC[i][8:5]));
            chk($sformatf("R6/R7/R8 vec %0d illegal", i), 64'(illegal_o), 64'(VEC[i][4]));
            chk($sformatf("R3/R4/R5 vec %0d open", i), 64'(bank_open_o), 64'(VEC[i][3:0]));
        end

        chk("R8 mode register", 64'(mode_o), 64'h0033);
        chk("R8 ext mode register", 64'(ext_mode_o), 64'h0102);
        chk("R9 refresh row after one", 64'(ref_row_o), 64'd1);
        apply(5'b10001, 2'd0, 13'h0000);
        chk("R9 refresh row after two", 64'(ref_row_o), 64'd2);

        // R3 row storage, R6 illegal activate leaves the row
        apply(5'b10011, 2'd1, 13'h0321);
        chk("R3 row bank1", 64'(open_rows_o[13 +: 13]), 64'h0321);
        apply(5'b10011, 2'd1, 13'h0AAA);
        chk("R6 row kept", 64'(open_rows_o[13 +: 13]), 64'h0321);
        chk("R6 flagged", 64'(illegal_o), 64'd1);
        // R5 read with auto precharge
        apply(5'b10101, 2'd1, 13'h0400);
        chk("R5 auto_pre", 64'({auto_pre_o, bank_open_o}), 64'b1_0000);

        // R10 self refresh collision with exit edge
        apply(5'b00001, 2'd0, 13'h0000);
        chk("R2 sref entry", 64'({cmd_o, pwr_o}), 64'({4'd9, 2'd1}));
        apply(5'b00011, 2'd0, 13'h0010);
        chk("R10 ignored while low", 64'({cmd_o, pwr_o, bank_open_o}), 64'({4'd0, 2'd1, 4'b0000}));
        apply(5'b10011, 2'd0, 13'h0010);
        chk("R10 exit edge ignored", 64'({cmd_o, pwr_o, bank_open_o}), 64'({4'd0, 2'd0, 4'b0000}));
        apply(5'b10011, 2'd0, 13'h0010);
        chk("R10 active after exit", 64'({cmd_o, bank_open_o}), 64'({4'd1, 4'b0001}));

        // R2 deep power down; mode set while down is dropped
        apply(5'b00110, 2'd0, 13'h0000);
        chk("R2 dpd entry", 64'({cmd_o, pwr_o}), 64'({4'd5, 2'd2}));
        apply(5'b00000, 2'd0, 13'h1234);
        chk("R10 mode untouched", 64'({cmd_o, mode_o}), 64'({4'd0, 13'h0033}));
        apply(5'b10111, 2'd0, 13'h0000);
        chk("R10 dpd exit", 64'(pwr_o), 64'd0);

        // R11 dqm pipeline: single low pulse
        apply(5'b10111, 2'd0, 13'h0000);
        apply(5'b10111, 2'd0, 13'h0000);
        dqm = 1'b0;
        apply(5'b10111, 2'd0, 13'h0000);
        chk("R11 mask edge1", 64'({wr_mask_o, rd_oe_o}), 64'b00);
        dqm = 1'b1;
        apply(5'b10111, 2'd0, 13'h0000);
        chk("R11 edge2", 64'({wr_mask_o, rd_oe_o}), 64'b10);
        apply(5'b10111, 2'd0, 13'h0000);
        chk("R11 oe edge3", 64'({wr_mask_o, rd_oe_o}), 64'b11);
        apply(5'b10111, 2'd0, 13'h0000);
        chk("R11 oe edge4", 64'(rd_oe_o), 64'd0);

        // R4 single precharge leaves others; then mid-run reset
        apply(5'b10011, 2'd2, 13'h0001);
        apply(5'b10010, 2'd0, 13'h0000);
        chk("R4 single bank", 64'(bank_open_o), 64'b0100);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset("R12 mid-run");

        done = 1;
        summary();
    end
endmodule